// File: doc/BRIEF.md
# Dual-Slot Card Status Change Unit

This block watches the status pins of two removable-card slots and reports them through three shared 32-bit registers. Each slot has eight pins: two voltage-sense lines, write protect, two card-detect lines, two battery-voltage lines and ready. Every pin is brought into the clock domain through two flops. The synchronized values appear in a pin register. Changes on them are latched into a status-change register that software clears by writing ones. An enable register selects which status bits may drive the single interrupt request.

In every shared register, slot A uses bits 31:16 and slot B uses bits 15:0. Slot B's positions are slot A's positions shifted right by 16. The ready pin feeds four event bits per slot:
- a level-low bit and a level-high bit, which follow the pin with no latching;
- a rising-edge bit and a falling-edge bit, which latch.

Card-detect changes are only reported once both detect lines agree. A per-slot summary is also decoded for direct use: card presence, write protect, ready, the battery pair, the voltage-sense code and its low-voltage card decode.

Top module: `card_status_unit`

## Requirements
- R1: Register address 0 reads the synchronized pins. Slot A uses bits 31:24 in the order VS1 (31), VS2 (30), WP (29), CD2 (28), CD1 (27), BVD2 (26), BVD1 (25), RDY (24). Slot B uses bits 15:8 in the same order. All other bits read 0. A pin change is visible after the second rising clock edge.
- R2: Address 1 reads the status-change register. For VS1, VS2, WP, BVD2, BVD1 and RDY, a change of the synchronized pin sets the bit at that pin's position (the same position as in R1) on the third rising edge after the pin changes. The bit then stays set.
- R3: The two card-detect change bits of a slot (28 and 27 for A, 12 and 11 for B) set together, only when both detect pins are equal and the presence they encode differs from the last agreed presence. A state where the detect pins disagree sets neither bit.
- R4: A write to address 1 clears every latched status bit written as one. Bits written as zero keep their value. A set in the same cycle wins over the clear.
- R5: Bit 23 (slot A) and bit 7 (slot B) read 1 while the synchronized ready pin is low. Bit 22 and bit 6 read 1 while it is high. Writes do not affect these four bits.
- R6: A rising edge of the synchronized ready pin latches bit 21 (A) or bit 5 (B). A falling edge latches bit 20 (A) or bit 4 (B).
- R7: Address 2 is the enable register. It can be read and written. Only bits 31:20 and 15:4 are implemented, and other bits read 0. Address 3 reads 0.
- R8: irq is high exactly when some status-change bit of either slot and its enable bit are both 1.
- R9: card_present of a slot is 1 only when both of its detect pins are low. write_prot, card_ready and batt_volt (BVD2 upper, BVD1 lower) show the synchronized pins. Index 1 is slot A and index 0 is slot B.
- R10: vs_code gives {VS1, VS2} of each slot, with slot A in bits 3:2. With LV_SOCKET set, code 01 drives card_3v3 and code 10 drives card_xv.
- R11: After reset, the enable register and all latched status bits are 0 and irq is low. Pin levels present during reset raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_a_pins | input | 8 | Slot A raw pins {VS1,VS2,WP,CD2,CD1,BVD2,BVD1,RDY} |
| slot_b_pins | input | 8 | Slot B raw pins, same order |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pins, 1 status change, 2 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Interrupt request |
| card_present | output | 2 | Card present per slot |
| write_prot | output | 2 | Write protect per slot |
| card_ready | output | 2 | Ready per slot |
| batt_volt | output | 4 | Battery pair per slot |
| vs_code | output | 4 | Voltage-sense code per slot |
| card_3v3 | output | 2 | 3.3 V-only card decoded |
| card_xv | output | 2 | x.x V-only card decoded |

## Verification
The bench drives the detect lines into a state where they disagree. It checks that no detect change bit appears then, and that the bits do appear once both lines agree. A design that reported per line would raise spurious insertion interrupts. It writes ones over the ready level bits and expects them to keep following the pin. It writes zeros to the status-change register and expects nothing to clear. Random pin patterns for both slots at once catch a slot B field shifted to the wrong position. They also catch one slot's clear reaching the other slot.

// File: rtl/card_status_unit.sv
module card_status_unit #(
  parameter bit LV_SOCKET = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  slot_a_pins,
  input  logic [7:0]  slot_b_pins,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic [1:0]  card_present,
  output logic [1:0]  write_prot,
  output logic [1:0]  card_ready,
  output logic [3:0]  batt_volt,
  output logic [3:0]  vs_code,
  output logic [1:0]  card_3v3,
  output logic [1:0]  card_xv
);
  localparam int          HALF     = 16;
  localparam logic [15:0] EN_HALF  = 16'hFFF0;
  localparam logic [7:0]  PLAIN    = 8'hE7;
  localparam logic [7:0]  CD_PAIR  = 8'h18;

  logic [15:0] pins_all;
  logic [1:0]  warm;
  logic        armed, load;
  logic        clr_sel;
  logic [31:0] pin_word, chg_word, en_word;

  assign pins_all = {slot_a_pins, slot_b_pins};
  assign armed    = (warm == 2'd3);
  assign load     = (warm == 2'd2);
  assign clr_sel  = reg_wr && (reg_addr == 2'd1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         warm <= 2'd0;
    else if (!armed)    warm <= warm + 2'd1;

  for (genvar g = 0; g < 2; g++) begin : g_slot
    logic [7:0] s1, s2, prev, chg, set8, clr_pin;
    logic       rise, fall, settled, clr_r, clr_f, cd_evt, now_present;

    assign clr_pin     = clr_sel ? reg_wdata[HALF*g+8 +: 8] : 8'h00;
    assign clr_r       = clr_sel & reg_wdata[HALF*g+5];
    assign clr_f       = clr_sel & reg_wdata[HALF*g+4];
    assign now_present = (s2[4:3] == 2'b00);
    assign cd_evt      = armed && (s2[4] == s2[3]) && (now_present != settled);
    assign set8        = (armed ? ((s2 ^ prev) & PLAIN) : 8'h00) | (cd_evt ? CD_PAIR : 8'h00);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1      <= '0;
        s2      <= '0;
        prev    <= '0;
        chg     <= '0;
        rise    <= 1'b0;
        fall    <= 1'b0;
        settled <= 1'b0;
      end else begin
        s1   <= pins_all[8*g +: 8];
        s2   <= s1;
        prev <= s2;
        if (load || cd_evt) settled <= now_present;
        chg  <= (chg & ~clr_pin) | set8;
        rise <= (rise & ~clr_r) | (armed & s2[0] & ~prev[0]);
        fall <= (fall & ~clr_f) | (armed & ~s2[0] & prev[0]);
      end
    end

    assign pin_word[HALF*g +: HALF] = {s2, 8'h00};
    assign chg_word[HALF*g +: HALF] = {chg, ~s2[0], s2[0], rise, fall, 4'h0};

    assign card_present[g]   = now_present;
    assign write_prot[g]     = s2[5];
    assign card_ready[g]     = s2[0];
    assign batt_volt[2*g +: 2] = s2[2:1];
    assign vs_code[2*g +: 2]   = s2[7:6];

    if (LV_SOCKET) begin : g_lv
      assign card_3v3[g] = (s2[7:6] == 2'b01);
      assign card_xv[g]  = (s2[7:6] == 2'b10);
    end else begin : g_nolv
      assign card_3v3[g] = 1'b0;
      assign card_xv[g]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             en_word <= '0;
    else if (reg_wr && reg_addr == 2'd2)    en_word <= reg_wdata & {EN_HALF, EN_HALF};

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = pin_word;
      2'd1:    reg_rdata = chg_word;
      2'd2:    reg_rdata = en_word;
      default: reg_rdata = 32'h0;
    endcase

  assign irq = |(chg_word & en_word);
endmodule

module card_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  slot_a_pins,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        irq,
  input logic [1:0]  card_present,
  input logic [31:0] chg_word,
  input logic [31:0] en_word
);
  localparam logic [31:0] LATCHED = 32'hFF30FF30;
  localparam logic [31:0] EN_MASK = 32'hFFF0FFF0;
  logic [1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           cnt <= 2'd0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;

  p_enable_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> (en_word == ($past(reg_wdata) & EN_MASK)));

  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && reg_wdata == 32'h0) |=> !irq);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd1) |=> ((($past(chg_word) & LATCHED) & ~chg_word) == 32'h0));

  p_quiet_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 2'd3) |-> ((chg_word & LATCHED) == 32'h0));

  p_present_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3) |-> (card_present[1] == ($past(slot_a_pins[4:3], 2) == 2'b00)));
endmodule

bind card_status_unit card_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slot_a_pins(slot_a_pins), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq),
  .card_present(card_present), .chg_word(chg_word), .en_word(en_word)
);

// File: tb/card_status_unit_test.sv
module card_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  slot_a_pins, slot_b_pins;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;
  logic [1:0]  card_present, write_prot, card_ready, card_3v3, card_xv;
  logic [3:0]  batt_volt, vs_code;

  always #2 clk = ~clk;

  card_status_unit uut (
    .clk(clk), .rst_n(rst_n), .slot_a_pins(slot_a_pins), .slot_b_pins(slot_b_pins),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .card_present(card_present), .write_prot(write_prot),
    .card_ready(card_ready), .batt_volt(batt_volt), .vs_code(vs_code),
    .card_3v3(card_3v3), .card_xv(card_xv)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0]  m_pin [2];
  logic [7:0]  m_chg [2];
  logic        m_rise[2], m_fall[2], m_pres[2];
  logic [31:0] m_en;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] half(input int s);
    return {m_chg[s], ~m_pin[s][0], m_pin[s][0], m_rise[s], m_fall[s], 4'h0};
  endfunction

  function automatic logic [31:0] exp_chg();
    return {half(1), half(0)};
  endfunction

  task automatic model_pins(input int s, input logic [7:0] n);
    logic [7:0] o;
    o = m_pin[s];
    m_chg[s] |= (o ^ n) & 8'hE7;
    if (n[4] == n[3] && ((n[4:3] == 2'b00) != m_pres[s])) begin
      m_chg[s] |= 8'h18;
      m_pres[s] = (n[4:3] == 2'b00);
    end
    if (n[0] & ~o[0]) m_rise[s] = 1'b1;
    if (~n[0] & o[0]) m_fall[s] = 1'b1;
    m_pin[s] = n;
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    slot_a_pins = a;
    slot_b_pins = b;
    model_pins(1, a);
    model_pins(0, b);
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] ad, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ad; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (ad == 2'd2) m_en = d & 32'hFFF0FFF0;
    if (ad == 2'd1)
      for (int s = 0; s < 2; s++) begin
        m_chg[s]  &= ~d[16*s+8 +: 8];
        if (d[16*s+5]) m_rise[s] = 1'b0;
        if (d[16*s+4]) m_fall[s] = 1'b0;
      end
  endtask

  task automatic rd(input logic [1:0] ad, output logic [31:0] d);
    reg_addr = ad;
    #1;
    d = reg_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    rd(2'd0, d); chk("R1 pin register", d, {m_pin[1], 8'h00, m_pin[0], 8'h00});
    rd(2'd1, d); chk({tag, " status change"}, d, exp_chg());
    rd(2'd2, d); chk("R7 enable", d, m_en);
    chk("R8 irq", {31'h0, irq}, {31'h0, |(exp_chg() & m_en)});
    chk("R9 present", {30'h0, card_present},
        {30'h0, m_pin[1][4:3] == 2'b00, m_pin[0][4:3] == 2'b00});
    chk("R9 wp/ready/batt", {24'h0, write_prot, card_ready, batt_volt},
        {24'h0, m_pin[1][5], m_pin[0][5], m_pin[1][0], m_pin[0][0], m_pin[1][2:1], m_pin[0][2:1]});
    chk("R10 vs decode", {24'h0, vs_code, card_3v3, card_xv},
        {24'h0, m_pin[1][7:6], m_pin[0][7:6],
         m_pin[1][7:6] == 2'b01, m_pin[0][7:6] == 2'b01,
         m_pin[1][7:6] == 2'b10, m_pin[0][7:6] == 2'b10});
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    slot_a_pins = 8'hFF; slot_b_pins = 8'hFF;
    for (int s = 0; s < 2; s++) begin
      m_pin[s] = 8'hFF; m_chg[s] = 8'h00; m_rise[s] = 1'b0; m_fall[s] = 1'b0; m_pres[s] = 1'b0;
    end
    m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    rd(2'd1, d); chk("R11 no events after reset", d & 32'hFF30FF30, 32'h0);
    chk("R11 irq low", {31'h0, irq}, 32'h0);
    check_all("R11");

    // R7 implemented enable bits and unused address
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R7 enable mask", d, 32'hFFF0_FFF0);
    rd(2'd3, d); chk("R7 address 3", d, 32'h0);
    chk("R8 level bit enabled", {31'h0, irq}, 32'h1);
    wr(2'd2, 32'h0);
    chk("R8 all disabled", {31'h0, irq}, 32'h0);

    // R5/R6 ready low on slot A
    apply(8'hFE, 8'hFF);
    rd(2'd1, d);
    chk("R5 level bits A", {30'h0, d[23:22]}, 32'h2);
    chk("R6 fall A", {31'h0, d[20]}, 32'h1);
    chk("R2 rdy change A", {31'h0, d[24]}, 32'h1);
    wr(2'd1, 32'h00F0_00F0);
    rd(2'd1, d);
    chk("R5 level bits unaffected by write", {30'h0, d[23:22]}, 32'h2);
    chk("R4 fall cleared", {31'h0, d[20]}, 32'h0);
    apply(8'hFF, 8'hFE);
    rd(2'd1, d);
    chk("R6 rise A", {31'h0, d[21]}, 32'h1);
    chk("R6 fall B", {31'h0, d[4]}, 32'h1);
    check_all("R6");

    // R4 zero write keeps, ones clear
    wr(2'd1, 32'h0);
    check_all("R4 zero write");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R4 all cleared", d & 32'hFF30FF30, 32'h0);

    // R3 detect lines disagreeing, then agreeing
    apply(8'hEF, 8'hFE);
    rd(2'd1, d); chk("R3 mismatch no detect change", {30'h0, d[28:27]}, 32'h0);
    apply(8'hE7, 8'hFE);
    rd(2'd1, d); chk("R3 inserted detect change", {30'h0, d[28:27]}, 32'h3);
    chk("R9 present A", {30'h0, card_present}, 32'h2);
    wr(2'd1, 32'h1800_0000);
    apply(8'hF7, 8'hFE);
    rd(2'd1, d); chk("R3 partial removal silent", {30'h0, d[28:27]}, 32'h0);
    apply(8'hFF, 8'hE6);
    rd(2'd1, d);
    chk("R3 removal A", {30'h0, d[28:27]}, 32'h3);
    chk("R3 insertion B", {30'h0, d[12:11]}, 32'h3);
    check_all("R3");

    // R10 voltage sense
    apply(8'h7F, 8'hA6);
    chk("R10 3v3 A", {30'h0, card_3v3}, 32'h2);
    chk("R10 xv B", {30'h0, card_xv}, 32'h1);

    // R8 single enable
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0000_0010);
    apply(8'h7F, 8'hA7);
    chk("R8 enabled rise B no irq", {31'h0, irq}, 32'h0);
    apply(8'h7F, 8'hA6);
    chk("R8 enabled fall B irq", {31'h0, irq}, 32'h1);

    // random mix, R2
    for (int i = 0; i < 60; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom); b = 8'($urandom);
      if ($urandom % 3 == 0) a[3] = a[4];
      if ($urandom % 3 == 0) b[3] = b[4];
      apply(a, b);
      check_all("R2");
      if (i % 5 == 4) begin
        wr(2'd1, $urandom);
        wr(2'd2, $urandom);
        check_all("R4");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule